// File: doc/BRIEF.md
# DRAM Single-Bit Access Strobe Sequencer

This block runs one single-bit access at a time on an asynchronous DRAM. The DRAM has a 10-bit multiplexed address bus, active-low row strobe, column strobe and write enable, a data-in line and a data-out line. The requester sends a request that carries a row, a column, a read or write flag and a write bit. The block then drives the row address, lowers the row strobe, moves the column address onto the bus and lowers the column strobe. For a write it uses a late-write ordering and releases the strobes in a fixed order. For a read it returns the sampled bit with a one-cycle completion pulse.

Each timing phase has a minimum length in clocks, set by parameters: address setup, row-to-column delay, column strobe width and precharge. Refresh is handled elsewhere, and so is the choice of which address to access.

Top module: `dram_strobe_seq`

## Requirements
- R1: After reset and whenever `busy` is low, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are all 1, `done` is 0, and `rd_data` is 0 until the first read completes.
- R2: The row address of the request is on `dram_addr` for at least one cycle before `dram_ras_n` falls, and it is still there when `dram_ras_n` falls.
- R3: The column address is driven while `dram_ras_n` is low and is stable on `dram_addr` when `dram_cas_n` falls. `dram_cas_n` falls only while `dram_ras_n` is low.
- R4: In a write, `dram_d` carries the write bit from the cycle `dram_ras_n` falls. `dram_we_n` falls after the column address is on the bus, while `dram_cas_n` is still high, and at least one cycle before `dram_cas_n` falls.
- R5: A write ends in this order, one step per cycle: `dram_we_n` rises while both strobes are low, then `dram_ras_n` rises while `dram_cas_n` is still low, then `dram_cas_n` rises.
- R6: In a read, `dram_we_n` stays 1. `dram_q` is sampled in the last cycle that `dram_cas_n` is low, and `dram_ras_n` and `dram_cas_n` rise in the same cycle.
- R7: `busy` is 1 from the cycle after acceptance through the cycle of `done`, with no gap. `done` is a single-cycle pulse in the last busy cycle. `busy` is 0 in the following cycle.
- R8: A request is accepted only while `busy` is 0. A `req_valid` that is held or presented while busy has no effect on the DRAM.
- R9: `rd_data` holds the last read bit from its `done` pulse until the next read completes. A write does not change it.
- R10: A read keeps `busy` high for 2*T_ASU+T_RCD+T_CAS+T_PRE cycles. A write keeps it high for 3*T_ASU+T_RCD+T_CAS+T_PRE+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | 10 | Row address |
| req_col | input | 10 | Column address |
| req_wdata | input | 1 | Bit to write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 1 | Last bit read |
| dram_addr | output | 10 | Multiplexed DRAM address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_d | output | 1 | Data to DRAM |
| dram_q | input | 1 | Data from DRAM |

## Verification
If the sequencer skips a phase or takes a wrong branch, the busy length changes at once, or the strobe edges come in the wrong order in the same access. The bench sees this at the next falling clock edge. A wrong address latch or a wrong capture point leaves a bad bit in the DRAM model. That bit shows up as a wrong `rd_data` on the next read of that location, so the bench writes locations and later reads them back.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ROW_SU,
      ST_RAS_LO,
      ST_COL_SU,
      ST_WE_LO,
      ST_CAS_LO,
      ST_WE_REL,
      ST_RAS_REL,
      ST_PRE
   } seq_state_t;
endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign last = (cnt == '0);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
   import dram_seq_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int T_ASU = 1,
   parameter int T_RCD = 2,
   parameter int T_CAS = 2,
   parameter int T_PRE = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             op_write,
   input  logic             tmr_last,
   output seq_state_t       state,
   output logic             accept,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val
);
   localparam logic [CNT_W-1:0] LD_ASU = CNT_W'(T_ASU - 1);
   localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
   localparam logic [CNT_W-1:0] LD_CAS = CNT_W'(T_CAS - 1);
   localparam logic [CNT_W-1:0] LD_PRE = CNT_W'(T_PRE - 1);

   seq_state_t nxt;

   assign accept = (state == ST_IDLE) && req_valid;

   always_comb begin
      nxt      = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state)
         ST_IDLE: if (req_valid) begin
            nxt = ST_ROW_SU; tmr_load = 1'b1; tmr_val = LD_ASU;
         end
         ST_ROW_SU: if (tmr_last) begin
            nxt = ST_RAS_LO; tmr_load = 1'b1; tmr_val = LD_RCD;
         end
         ST_RAS_LO: if (tmr_last) begin
            nxt = ST_COL_SU; tmr_load = 1'b1; tmr_val = LD_ASU;
         end
         ST_COL_SU: if (tmr_last) begin
            tmr_load = 1'b1;
            if (op_write) begin nxt = ST_WE_LO;  tmr_val = LD_ASU; end
            else          begin nxt = ST_CAS_LO; tmr_val = LD_CAS; end
         end
         ST_WE_LO: if (tmr_last) begin
            nxt = ST_CAS_LO; tmr_load = 1'b1; tmr_val = LD_CAS;
         end
         ST_CAS_LO: if (tmr_last) begin
            tmr_load = 1'b1;
            if (op_write) begin nxt = ST_WE_REL; tmr_val = '0; end
            else          begin nxt = ST_PRE;    tmr_val = LD_PRE; end
         end
         ST_WE_REL: begin
            nxt = ST_RAS_REL; tmr_load = 1'b1; tmr_val = '0;
         end
         ST_RAS_REL: begin
            nxt = ST_PRE; tmr_load = 1'b1; tmr_val = LD_PRE;
         end
         ST_PRE: if (tmr_last) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/seq_rd_capture.sv
module seq_rd_capture (
   input  logic clk,
   input  logic rst_n,
   input  logic sample,
   input  logic q_in,
   output logic rd_bit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_bit <= 1'b0;
      else if (sample) rd_bit <= q_in;
   end
endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
   import dram_seq_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int CNT_W  = 4,
   parameter int T_ASU  = 1,
   parameter int T_RCD  = 2,
   parameter int T_CAS  = 2,
   parameter int T_PRE  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_row,
   input  logic [ADDR_W-1:0] req_col,
   input  logic              req_wdata,
   output logic              busy,
   output logic              done,
   output logic              rd_data,
   output logic [ADDR_W-1:0] dram_addr,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic              dram_d,
   input  logic              dram_q
);
   localparam int CNT_MAX = (1 << CNT_W);

   generate
      if (T_ASU < 1 || T_ASU > CNT_MAX) begin : g_bad_asu
         $error("T_ASU out of range");
      end
      if (T_RCD < 1 || T_RCD > CNT_MAX) begin : g_bad_rcd
         $error("T_RCD out of range");
      end
      if (T_CAS < 1 || T_CAS > CNT_MAX) begin : g_bad_cas
         $error("T_CAS out of range");
      end
      if (T_PRE < 1 || T_PRE > CNT_MAX) begin : g_bad_pre
         $error("T_PRE out of range");
      end
      if (ADDR_W < 1) begin : g_bad_aw
         $error("ADDR_W must be positive");
      end
   endgenerate

   seq_state_t       state;
   logic             accept, tmr_load, tmr_last;
   logic [CNT_W-1:0] tmr_val;
   logic [ADDR_W-1:0] row_q, col_q;
   logic             wr_q, wbit_q;
   logic             col_phase, ras_low, cas_low, we_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q  <= '0;
         col_q  <= '0;
         wr_q   <= 1'b0;
         wbit_q <= 1'b0;
      end else if (accept) begin
         row_q  <= req_row;
         col_q  <= req_col;
         wr_q   <= req_write;
         wbit_q <= req_wdata;
      end
   end

   seq_fsm #(
      .CNT_W(CNT_W), .T_ASU(T_ASU), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_PRE(T_PRE)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_write(wr_q),
      .tmr_last(tmr_last), .state(state), .accept(accept),
      .tmr_load(tmr_load), .tmr_val(tmr_val)
   );

   seq_phase_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
   );

   seq_rd_capture u_cap (
      .clk(clk), .rst_n(rst_n),
      .sample((state == ST_CAS_LO) && tmr_last && !wr_q),
      .q_in(dram_q), .rd_bit(rd_data)
   );

   always_comb begin
      col_phase = state inside {ST_COL_SU, ST_WE_LO, ST_CAS_LO, ST_WE_REL, ST_RAS_REL};
      ras_low   = state inside {ST_RAS_LO, ST_COL_SU, ST_WE_LO, ST_CAS_LO, ST_WE_REL};
      cas_low   = state inside {ST_CAS_LO, ST_WE_REL, ST_RAS_REL};
      we_low    = (state == ST_WE_LO) || ((state == ST_CAS_LO) && wr_q);
   end

   assign dram_addr  = col_phase ? col_q : row_q;
   assign dram_ras_n = ~ras_low;
   assign dram_cas_n = ~cas_low;
   assign dram_we_n  = ~we_low;
   assign dram_d     = wr_q && (ras_low || cas_low) ? wbit_q : 1'b0;
   assign busy       = (state != ST_IDLE);
   assign done       = (state == ST_PRE) && tmr_last;
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr
);
   // R1
   idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ras_n && cas_n && we_n && !done));
   // R2
   row_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> $stable(addr) && cas_n);
   // R3
   col_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> $stable(addr) && !ras_n);
   // R4
   we_before_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> cas_n && !ras_n);
   // R5
   we_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> !ras_n && !cas_n);
   // R5
   cas_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_n) |-> ras_n);
   // R7
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy ##1 !busy);
endmodule

bind dram_strobe_seq dram_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .addr(dram_addr)
);

// File: tb/dram_strobe_seq_tb.sv
`timescale 1ns/1ps
module dram_strobe_seq_tb;
   localparam int T_ASU = 1, T_RCD = 2, T_CAS = 2, T_PRE = 2;
   localparam int LEN_RD = 2*T_ASU + T_RCD + T_CAS + T_PRE;
   localparam int LEN_WR = LEN_RD + T_ASU + 2;
   localparam int NV = 9;
   // {write, row, col, bit}
   localparam logic [21:0] VEC [0:NV-1] = '{
      {1'b1, 10'h3FF, 10'h3FF, 1'b1},
      {1'b1, 10'h000, 10'h000, 1'b1},
      {1'b1, 10'h003, 10'h007, 1'b1},
      {1'b0, 10'h003, 10'h007, 1'b0},
      {1'b0, 10'h3FF, 10'h3FF, 1'b0},
      {1'b0, 10'h000, 10'h000, 1'b0},
      {1'b1, 10'h003, 10'h007, 1'b0},
      {1'b0, 10'h003, 10'h007, 1'b0},
      {1'b0, 10'h001, 10'h001, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
   logic [9:0] req_row = '0, req_col = '0;
   logic busy, done, rd_data, ras_n, cas_n, we_n, d;
   logic [9:0] addr;
   logic q = 1'b0;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   bit dmem [int];
   bit emem [int];
   logic cur_wr = 1'b0, cur_bit = 1'b0;
   logic [9:0] cur_row = '0, cur_col = '0;
   logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;

   always #2.5 clk = ~clk;

   dram_strobe_seq #(.T_ASU(T_ASU), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_PRE(T_PRE)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data), .dram_addr(addr),
      .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
      .dram_d(d), .dram_q(q)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit rd_mem(input bit use_exp, input int k);
      if (use_exp) return emem.exists(k) ? emem[k] : 1'b0;
      return dmem.exists(k) ? dmem[k] : 1'b0;
   endfunction

   // DRAM model and edge-order monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (p_ras && !ras_n) begin
            chk(addr == cur_row, "R2 row at RAS fall", addr, cur_row);
            chk(cas_n == 1'b1, "R2 CAS high at RAS fall", cas_n, 1);
         end
         if (p_cas && !cas_n) begin
            chk(addr == cur_col, "R3 col at CAS fall", addr, cur_col);
            chk(!ras_n && !p_ras, "R3 RAS low before CAS", ras_n, 0);
            if (!we_n) begin
               chk(cur_wr && !p_we, "R4 WE low before CAS", p_we, 0);
               chk(d == cur_bit, "R4 write data", d, cur_bit);
               dmem[{cur_row, cur_col}] = d;
            end else begin
               chk(!cur_wr, "R6 WE high on read", we_n, 1);
               q <= rd_mem(0, {cur_row, cur_col});
            end
         end
         if (!p_ras && !ras_n && cur_wr)
            chk(d == cur_bit, "R4 D held while RAS low", d, cur_bit);
         if (!p_we && we_n)
            chk(!ras_n && !cas_n, "R5 WE rises first", {ras_n, cas_n}, 0);
         if (!p_ras && ras_n) begin
            if (cur_wr) chk(we_n && !cas_n, "R5 RAS rises second", {we_n, cas_n}, 2);
            else        chk(cas_n, "R6 RAS and CAS rise together", cas_n, 1);
         end
         if (!p_cas && cas_n) begin
            chk(ras_n, "R5 CAS rises last", ras_n, 1);
            q <= 1'b0;
         end
         if (!busy) chk(ras_n && cas_n && we_n, "R1 idle strobes", {ras_n, cas_n, we_n}, 7);
      end
      p_ras <= ras_n; p_cas <= cas_n; p_we <= we_n;
   end

   task automatic run_req(input logic wr, input logic [9:0] row, input logic [9:0] col,
                          input logic b, input int hold);
      int cyc = 0;
      int h = hold;
      bit seen = 0;
      bit gap = 0;
      bit old_rd;
      @(negedge clk);
      chk(!busy, "R8 idle before request", busy, 0);
      cur_wr = wr; cur_row = row; cur_col = col; cur_bit = b;
      req_valid = 1'b1; req_write = wr; req_row = row; req_col = col; req_wdata = b;
      old_rd = rd_data;
      @(negedge clk);
      // R8: extra request while busy targets another location
      req_write = 1'b1; req_row = ~row; req_col = ~col; req_wdata = 1'b1;
      if (h == 0) req_valid = 1'b0;
      while (!seen && cyc < 100) begin
         if (busy) cyc++; else gap = 1;
         if (done) seen = 1;
         else begin
            if (!wr && !busy) ;
            if (wr) chk(rd_data == old_rd, "R9 write leaves rd_data", rd_data, old_rd);
            @(negedge clk);
            if (h > 0) begin h--; if (h == 0) req_valid = 1'b0; end
         end
      end
      req_valid = 1'b0;
      chk(seen && !gap, "R7 busy until done", gap, 0);
      chk(cyc == (wr ? LEN_WR : LEN_RD), "R10 busy length", cyc, wr ? LEN_WR : LEN_RD);
      if (wr) emem[{row, col}] = b;
      else chk(rd_data == rd_mem(1, {row, col}), "R6 read data", rd_data, rd_mem(1, {row, col}));
      old_rd = rd_data;
      @(negedge clk);
      chk(!busy && !done, "R7 done single pulse", {busy, done}, 0);
      chk(rd_data == old_rd, "R9 rd_data held after done", rd_data, old_rd);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         chk(0, "watchdog", 0, 1);
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(ras_n && cas_n && we_n, "R1 reset strobes", {ras_n, cas_n, we_n}, 7);
      chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
      chk(rd_data == 1'b0, "R1 reset rd_data", rd_data, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy, "R1 idle after reset", busy, 0);

      for (int i = 0; i < NV; i++)
         run_req(VEC[i][21], VEC[i][20:11], VEC[i][10:1], VEC[i][0], 0);

      // R8: request held high for several busy cycles with another address
      run_req(1'b1, 10'h055, 10'h0AA, 1'b1, 4);
      run_req(1'b0, ~10'h055, ~10'h0AA, 1'b0, 0);
      chk(rd_data == 1'b0, "R8 busy request ignored", rd_data, 0);
      run_req(1'b0, 10'h055, 10'h0AA, 1'b0, 0);
      chk(rd_data == 1'b1, "R6 read back held-request write", rd_data, 1);

      // R9: writes after a read of 1 keep rd_data at 1
      run_req(1'b1, 10'h200, 10'h100, 1'b0, 0);
      run_req(1'b1, 10'h201, 10'h101, 1'b0, 0);
      chk(rd_data == 1'b1, "R9 rd_data across writes", rd_data, 1);

      // back-to-back reads with toggling result
      run_req(1'b0, 10'h200, 10'h100, 1'b0, 0);
      chk(rd_data == 1'b0, "R9 rd_data updates on read", rd_data, 0);
      run_req(1'b0, 10'h3FF, 10'h3FF, 1'b0, 0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule